// File: doc/BRIEF.md
# Two-Level Page Walker with Translation Cache

This block turns a 24-bit virtual address into a 24-bit physical address for a system that uses 512-byte pages. Each request first looks in a 32-entry fully associative cache of recent translations. On a miss, the block walks two tables held in memory. The top index bits select a word in a first-level table whose base word address comes from a root input. That word points to a pointer table, and the middle index bits select the page entry inside it. The page entry gives the frame number. The walker then fills the cache and answers.

The walker keeps per-page usage state in memory. Every access marks the page entry as referenced, and every write also marks it as modified. A changed entry is written back before the response is given. An entry without its valid flag, at either level, ends the walk with a fault response, and nothing is cached for that page. A flush input empties the cache. New translations replace cache slots in strict rotation.

Top module: `pw_translator`

## Requirements
- R1: The virtual address splits into a first index in bits [23:16], a second index in bits [15:9] and a byte offset in bits [8:0]. The first-level word address is root_i + first index. The page-entry word address is (bits [15:0] of the first-level word) + second index.
- R2: Table words carry the valid flag in bit 31, referenced in bit 30, modified in bit 29, and the frame number in bits [14:0]. A successful response gives rsp_paddr_o = {frame, offset}.
- R3: A cache hit that needs no usage update answers with no memory access. rsp_valid_o is high for exactly one cycle, in the cycle after the cycle in which the request was accepted.
- R4: A first-level word with bit 31 clear gives a fault response after exactly one memory access. rsp_paddr_o is 0 in that response.
- R5: A page entry with bit 31 clear gives a fault response after two reads. The entry is not written and is not cached, so a repeat of the same access walks again.
- R6: A walk sets the referenced bit of the page entry. The entry is written back only when this changes it, so a walk over an already-referenced entry makes two accesses and a first-touch walk makes three. A read never clears or sets the modified bit.
- R7: A write sets the modified bit of the page entry. A write that hits a cached translation whose page is not yet modified performs a full walk with write-back. A later write to that page hits with no memory access.
- R8: The cache holds 32 translations and allocates slots in rotation, starting at slot 0 after reset or flush. After 32 fills, the next new page replaces the oldest translation while the others still hit.
- R9: flush_i invalidates every cached translation, so the next access to any page walks the tables.
- R10: The memory port runs one access at a time. Once mem_req_o is raised, it stays high with a stable address and direction until mem_ack_i.
- R11: req_ready_o is high only while the block is idle. A request is taken when req_valid_i and req_ready_o are both high, and ready is low in the cycle after that. After reset the block is idle with no response and no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Invalidate all cached translations |
| root_i | input | 16 | Word address of the first-level table |
| req_valid_i | input | 1 | Translation request |
| req_write_i | input | 1 | Request is a write access |
| req_vaddr_i | input | 24 | Virtual address |
| req_ready_o | output | 1 | Block idle, request accepted |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_fault_o | output | 1 | Response is a page fault |
| rsp_paddr_o | output | 24 | Physical address |
| mem_req_o | output | 1 | Table memory access request |
| mem_we_o | output | 1 | Access is a write-back |
| mem_addr_o | output | 16 | Table word address |
| mem_wdata_o | output | 32 | Entry written back |
| mem_rdata_i | input | 32 | Entry read, valid with ack |
| mem_ack_i | input | 1 | Access complete |

## Verification
The bench sweeps 33 pages spread over five first-level slots. It checks every frame arithmetically and counts memory accesses per request. The access count separates a hit (zero accesses), a walk over a referenced entry (two), a first touch or upgrade to modified (three), and the two fault kinds (one and two). Reads and writes are interleaved with flushes, so clean write hits, modified-page reads and rotation eviction each give a count that a wrong design could not match. Usage bits are read back from the table memory after each walk.

// File: rtl/pw_pkg.sv
package pw_pkg;
   localparam int PW_VLD = 31;
   localparam int PW_REF = 30;
   localparam int PW_MOD = 29;

   typedef enum logic [2:0] {
      W_IDLE,
      W_LOOK,
      W_RD1,
      W_RD2,
      W_WR,
      W_FILL
   } walk_st_t;
endpackage

// File: rtl/pw_tlb.sv
module pw_tlb #(
   parameter int N     = 32,
   parameter int VPN_W = 15,
   parameter int PFN_W = 15,
   localparam int IW   = $clog2(N)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             flush_i,
   input  logic [VPN_W-1:0] lk_vpn_i,
   output logic             lk_hit_o,
   output logic [IW-1:0]    lk_idx_o,
   output logic [PFN_W-1:0] lk_pfn_o,
   output logic             lk_mod_o,
   input  logic             fill_i,
   input  logic             fill_reuse_i,
   input  logic [IW-1:0]    fill_idx_i,
   input  logic [VPN_W-1:0] fill_vpn_i,
   input  logic [PFN_W-1:0] fill_pfn_i,
   input  logic             fill_mod_i
);
   if (N < 2 || (N & (N - 1)) != 0) begin : g_bad_depth
      $error("pw_tlb: N must be a power of two of at least 2");
   end

   logic [N-1:0]     vld_q;
   logic [N-1:0]     mod_q;
   logic [VPN_W-1:0] tag_q [N];
   logic [PFN_W-1:0] pfn_q [N];
   logic [N-1:0]     match;
   logic [IW-1:0]    ptr_q;
   logic [IW-1:0]    slot;

   for (genvar g = 0; g < N; g++) begin : g_cmp
      assign match[g] = vld_q[g] && (tag_q[g] == lk_vpn_i);
   end

   always_comb begin
      lk_idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (match[i]) lk_idx_o = IW'(i);
      end
   end

   assign lk_hit_o = |match;
   assign lk_pfn_o = pfn_q[lk_idx_o];
   assign lk_mod_o = mod_q[lk_idx_o];
   assign slot     = fill_reuse_i ? fill_idx_i : ptr_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni || flush_i) begin
         vld_q <= '0;
         ptr_q <= '0;
      end else if (fill_i) begin
         vld_q[slot] <= 1'b1;
         if (!fill_reuse_i) ptr_q <= ptr_q + 1'b1;
      end
   end

   always_ff @(posedge clk_i) begin
      if (fill_i) begin
         tag_q[slot] <= fill_vpn_i;
         pfn_q[slot] <= fill_pfn_i;
         mod_q[slot] <= fill_mod_i;
      end
   end
endmodule

// File: rtl/pw_walk.sv
module pw_walk
   import pw_pkg::*;
#(
   parameter int I1_W    = 8,
   parameter int I2_W    = 7,
   parameter int OFF_W   = 9,
   parameter int PFN_W   = 15,
   parameter int ENTRY_W = 32,
   parameter int MEM_AW  = 16,
   parameter int TLB_N   = 32,
   localparam int VA_W   = I1_W + I2_W + OFF_W,
   localparam int VPN_W  = I1_W + I2_W,
   localparam int PA_W   = PFN_W + OFF_W,
   localparam int IW     = $clog2(TLB_N)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [MEM_AW-1:0]  root_i,
   input  logic               req_valid_i,
   input  logic               req_write_i,
   input  logic [VA_W-1:0]    req_vaddr_i,
   output logic               req_ready_o,
   output logic               rsp_valid_o,
   output logic               rsp_fault_o,
   output logic [PA_W-1:0]    rsp_paddr_o,
   output logic               mem_req_o,
   output logic               mem_we_o,
   output logic [MEM_AW-1:0]  mem_addr_o,
   output logic [ENTRY_W-1:0] mem_wdata_o,
   input  logic [ENTRY_W-1:0] mem_rdata_i,
   input  logic               mem_ack_i,
   output logic [VPN_W-1:0]   lk_vpn_o,
   input  logic               lk_hit_i,
   input  logic [IW-1:0]      lk_idx_i,
   input  logic [PFN_W-1:0]   lk_pfn_i,
   input  logic               lk_mod_i,
   output logic               fill_o,
   output logic               fill_reuse_o,
   output logic [IW-1:0]      fill_idx_o,
   output logic [VPN_W-1:0]   fill_vpn_o,
   output logic [PFN_W-1:0]   fill_pfn_o,
   output logic               fill_mod_o
);
   walk_st_t           st_q;
   logic [VA_W-1:0]    va_q;
   logic               wr_q;
   logic               reuse_q;
   logic [IW-1:0]      ridx_q;
   logic [MEM_AW-1:0]  l2a_q;
   logic [ENTRY_W-1:0] ent_q;
   logic [ENTRY_W-1:0] upd;
   logic [I1_W-1:0]    idx1;
   logic [I2_W-1:0]    idx2;
   logic [OFF_W-1:0]   off;

   assign idx1 = va_q[VA_W-1 -: I1_W];
   assign idx2 = va_q[OFF_W +: I2_W];
   assign off  = va_q[OFF_W-1:0];

   always_comb begin
      upd = mem_rdata_i;
      upd[PW_REF] = 1'b1;
      if (wr_q) upd[PW_MOD] = 1'b1;
   end

   assign req_ready_o  = (st_q == W_IDLE);
   assign mem_req_o    = (st_q == W_RD1) || (st_q == W_RD2) || (st_q == W_WR);
   assign mem_we_o     = (st_q == W_WR);
   assign mem_addr_o   = (st_q == W_RD1) ? root_i + {{(MEM_AW-I1_W){1'b0}}, idx1} : l2a_q;
   assign mem_wdata_o  = ent_q;
   assign lk_vpn_o     = va_q[VA_W-1:OFF_W];
   assign fill_o       = (st_q == W_FILL);
   assign fill_reuse_o = reuse_q;
   assign fill_idx_o   = ridx_q;
   assign fill_vpn_o   = va_q[VA_W-1:OFF_W];
   assign fill_pfn_o   = ent_q[PFN_W-1:0];
   assign fill_mod_o   = ent_q[PW_MOD];

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         st_q        <= W_IDLE;
         va_q        <= '0;
         wr_q        <= 1'b0;
         reuse_q     <= 1'b0;
         ridx_q      <= '0;
         l2a_q       <= '0;
         ent_q       <= '0;
         rsp_valid_o <= 1'b0;
         rsp_fault_o <= 1'b0;
         rsp_paddr_o <= '0;
      end else begin
         rsp_valid_o <= 1'b0;
         unique case (st_q)
            W_IDLE: if (req_valid_i) begin
               va_q <= req_vaddr_i;
               wr_q <= req_write_i;
               st_q <= W_LOOK;
            end
            W_LOOK: begin
               if (lk_hit_i && (!wr_q || lk_mod_i)) begin
                  rsp_valid_o <= 1'b1;
                  rsp_fault_o <= 1'b0;
                  rsp_paddr_o <= {lk_pfn_i, off};
                  st_q        <= W_IDLE;
               end else begin
                  reuse_q <= lk_hit_i;
                  ridx_q  <= lk_idx_i;
                  st_q    <= W_RD1;
               end
            end
            W_RD1: if (mem_ack_i) begin
               if (!mem_rdata_i[PW_VLD]) begin
                  rsp_valid_o <= 1'b1;
                  rsp_fault_o <= 1'b1;
                  rsp_paddr_o <= '0;
                  st_q        <= W_IDLE;
               end else begin
                  l2a_q <= mem_rdata_i[MEM_AW-1:0] + {{(MEM_AW-I2_W){1'b0}}, idx2};
                  st_q  <= W_RD2;
               end
            end
            W_RD2: if (mem_ack_i) begin
               if (!mem_rdata_i[PW_VLD]) begin
                  rsp_valid_o <= 1'b1;
                  rsp_fault_o <= 1'b1;
                  rsp_paddr_o <= '0;
                  st_q        <= W_IDLE;
               end else begin
                  ent_q <= upd;
                  st_q  <= (upd != mem_rdata_i) ? W_WR : W_FILL;
               end
            end
            W_WR: if (mem_ack_i) st_q <= W_FILL;
            W_FILL: begin
               rsp_valid_o <= 1'b1;
               rsp_fault_o <= 1'b0;
               rsp_paddr_o <= {ent_q[PFN_W-1:0], off};
               st_q        <= W_IDLE;
            end
            default: st_q <= W_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/pw_translator.sv
module pw_translator
   import pw_pkg::*;
#(
   parameter int I1_W    = 8,
   parameter int I2_W    = 7,
   parameter int OFF_W   = 9,
   parameter int PFN_W   = 15,
   parameter int ENTRY_W = 32,
   parameter int MEM_AW  = 16,
   parameter int TLB_N   = 32,
   localparam int VA_W   = I1_W + I2_W + OFF_W,
   localparam int VPN_W  = I1_W + I2_W,
   localparam int PA_W   = PFN_W + OFF_W,
   localparam int IW     = $clog2(TLB_N)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               flush_i,
   input  logic [MEM_AW-1:0]  root_i,
   input  logic               req_valid_i,
   input  logic               req_write_i,
   input  logic [VA_W-1:0]    req_vaddr_i,
   output logic               req_ready_o,
   output logic               rsp_valid_o,
   output logic               rsp_fault_o,
   output logic [PA_W-1:0]    rsp_paddr_o,
   output logic               mem_req_o,
   output logic               mem_we_o,
   output logic [MEM_AW-1:0]  mem_addr_o,
   output logic [ENTRY_W-1:0] mem_wdata_o,
   input  logic [ENTRY_W-1:0] mem_rdata_i,
   input  logic               mem_ack_i
);
   if (ENTRY_W != 32) begin : g_bad_entry
      $error("pw_translator: table entries must be 32 bits");
   end
   if (MEM_AW > PW_MOD || PFN_W > PW_MOD) begin : g_bad_fields
      $error("pw_translator: address or frame field overlaps the flag bits");
   end
   if (I1_W > MEM_AW || I2_W > MEM_AW) begin : g_bad_index
      $error("pw_translator: index wider than memory address");
   end

   logic [VPN_W-1:0] lk_vpn;
   logic             lk_hit;
   logic [IW-1:0]    lk_idx;
   logic [PFN_W-1:0] lk_pfn;
   logic             lk_mod;
   logic             fill;
   logic             fill_reuse;
   logic [IW-1:0]    fill_idx;
   logic [VPN_W-1:0] fill_vpn;
   logic [PFN_W-1:0] fill_pfn;
   logic             fill_mod;

   pw_tlb #(.N(TLB_N), .VPN_W(VPN_W), .PFN_W(PFN_W)) tlb_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i),
      .lk_vpn_i(lk_vpn), .lk_hit_o(lk_hit), .lk_idx_o(lk_idx),
      .lk_pfn_o(lk_pfn), .lk_mod_o(lk_mod),
      .fill_i(fill), .fill_reuse_i(fill_reuse), .fill_idx_i(fill_idx),
      .fill_vpn_i(fill_vpn), .fill_pfn_i(fill_pfn), .fill_mod_i(fill_mod)
   );

   pw_walk #(
      .I1_W(I1_W), .I2_W(I2_W), .OFF_W(OFF_W), .PFN_W(PFN_W),
      .ENTRY_W(ENTRY_W), .MEM_AW(MEM_AW), .TLB_N(TLB_N)
   ) walk_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .root_i(root_i),
      .req_valid_i(req_valid_i), .req_write_i(req_write_i),
      .req_vaddr_i(req_vaddr_i), .req_ready_o(req_ready_o),
      .rsp_valid_o(rsp_valid_o), .rsp_fault_o(rsp_fault_o),
      .rsp_paddr_o(rsp_paddr_o),
      .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
      .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_ack_i(mem_ack_i),
      .lk_vpn_o(lk_vpn), .lk_hit_i(lk_hit), .lk_idx_i(lk_idx),
      .lk_pfn_i(lk_pfn), .lk_mod_i(lk_mod),
      .fill_o(fill), .fill_reuse_o(fill_reuse), .fill_idx_o(fill_idx),
      .fill_vpn_o(fill_vpn), .fill_pfn_o(fill_pfn), .fill_mod_o(fill_mod)
   );
endmodule

// File: rtl/pw_translator_chk.sv
module pw_translator_chk
   import pw_pkg::*;
#(
   parameter int VA_W    = 24,
   parameter int OFF_W   = 9,
   parameter int PA_W    = 24,
   parameter int MEM_AW  = 16,
   parameter int ENTRY_W = 32
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               req_valid_i,
   input logic               req_write_i,
   input logic [VA_W-1:0]    req_vaddr_i,
   input logic               req_ready_o,
   input logic               rsp_valid_o,
   input logic               rsp_fault_o,
   input logic [PA_W-1:0]    rsp_paddr_o,
   input logic               mem_req_o,
   input logic               mem_we_o,
   input logic [MEM_AW-1:0]  mem_addr_o,
   input logic [ENTRY_W-1:0] mem_wdata_o,
   input logic               mem_ack_i
);
   logic [VA_W-1:0] cap_va;
   logic            cap_wr;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cap_va <= '0;
         cap_wr <= 1'b0;
      end else if (req_valid_i && req_ready_o) begin
         cap_va <= req_vaddr_i;
         cap_wr <= req_write_i;
      end
   end

   AST_MEM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)); // R10
   AST_IDLE_NO_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_ready_o |-> !mem_req_o); // R11
   AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_valid_i && req_ready_o |=> !req_ready_o); // R11
   AST_RSP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rsp_valid_o |=> !rsp_valid_o); // R3
   AST_FAULT_ZERO_PA: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rsp_valid_o && rsp_fault_o |-> rsp_paddr_o == '0); // R4
   AST_WB_REF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_req_o && mem_we_o |-> mem_wdata_o[PW_REF] && mem_wdata_o[PW_VLD]); // R6
   AST_WB_MOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_req_o && mem_we_o && cap_wr |-> mem_wdata_o[PW_MOD]); // R7
   AST_OFFSET_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rsp_valid_o && !rsp_fault_o |-> rsp_paddr_o[OFF_W-1:0] == cap_va[OFF_W-1:0]); // R2
endmodule

bind pw_translator pw_translator_chk #(
   .VA_W(VA_W), .OFF_W(OFF_W), .PA_W(PA_W), .MEM_AW(MEM_AW), .ENTRY_W(ENTRY_W)
) chk_i (
   .clk_i(clk_i), .rst_ni(rst_ni),
   .req_valid_i(req_valid_i), .req_write_i(req_write_i), .req_vaddr_i(req_vaddr_i),
   .req_ready_o(req_ready_o), .rsp_valid_o(rsp_valid_o), .rsp_fault_o(rsp_fault_o),
   .rsp_paddr_o(rsp_paddr_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
   .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i)
);

// File: tb/pw_translator_tb_top.sv
module pw_translator_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam logic [15:0] ROOT = 16'h0100;
   localparam logic [31:0] VLD = 32'h8000_0000;
   localparam logic [31:0] REF = 32'h4000_0000;
   localparam logic [31:0] MOD = 32'h2000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [23:0] req_vaddr = '0;
   logic        req_ready;
   logic        rsp_valid;
   logic        rsp_fault;
   logic [23:0] rsp_paddr;
   logic        mem_req;
   logic        mem_we;
   logic [15:0] mem_addr;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        mem_ack = 1'b0;

   logic [31:0] mem_q [int];
   int acc_cnt = 0;
   int nchk = 0;
   int nfail = 0;
   logic busy_seen;

   always #(CLK_PERIOD / 2) clk = ~clk;

   pw_translator dut_i (
      .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .root_i(ROOT),
      .req_valid_i(req_valid), .req_write_i(req_write), .req_vaddr_i(req_vaddr),
      .req_ready_o(req_ready), .rsp_valid_o(rsp_valid), .rsp_fault_o(rsp_fault),
      .rsp_paddr_o(rsp_paddr), .mem_req_o(mem_req), .mem_we_o(mem_we),
      .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
      .mem_ack_i(mem_ack)
   );

   function automatic logic [31:0] rd(input int a);
      return mem_q.exists(a) ? mem_q[a] : 32'h0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack <= 1'b0;
      end else begin
         if (mem_req && mem_ack) acc_cnt <= acc_cnt + 1;
         mem_ack <= mem_req && !mem_ack;
         if (mem_req && !mem_ack) begin
            mem_rdata <= rd(int'(mem_addr));
            if (mem_we) mem_q[int'(mem_addr)] = mem_wdata;
         end
      end
   end

   function automatic int i1_of(input int p); return p >> 3; endfunction
   function automatic int i2_of(input int p); return (p % 8) * 13 + 5; endfunction
   function automatic int l2a_of(input int p); return 16'h1000 + i1_of(p) * 128 + i2_of(p); endfunction
   function automatic logic [14:0] pfn_of(input int p);
      return 15'((((i1_of(p) * 128 + i2_of(p)) * 7) + 3) & 32'h7fff);
   endfunction
   function automatic logic [23:0] va_of(input int p, input int off);
      return {8'(i1_of(p)), 7'(i2_of(p)), 9'(off)};
   endfunction

   task automatic chk(input bit ok, input string rq, input string what,
                      input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
      end
   endtask

   task automatic xlate(input logic [23:0] va, input logic wr,
                        output logic [23:0] pa, output logic flt,
                        output int nacc, output int lat);
      int a0;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1;
      req_vaddr = va;
      req_write = wr;
      a0 = acc_cnt;
      @(negedge clk);
      req_valid = 1'b0;
      busy_seen = !req_ready;
      lat = 0;
      while (!rsp_valid && lat < 200) begin
         @(negedge clk);
         lat++;
      end
      pa = rsp_paddr;
      flt = rsp_fault;
      nacc = acc_cnt - a0;
      if (lat >= 200) chk(1'b0, "R11", "response timeout", lat, 0);
   endtask

   task automatic do_flush();
      @(negedge clk);
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
   endtask

   task automatic page_ok(input int p, input int off, input logic wr,
                          input int exp_acc, input string rq);
      logic [23:0] pa;
      logic flt;
      int n;
      int lat;
      xlate(va_of(p, off), wr, pa, flt, n, lat);
      chk(!flt, rq, "no fault", flt, 0);
      chk(pa == {pfn_of(p), 9'(off)}, "R2", "paddr", pa, {pfn_of(p), 9'(off)});
      chk(n == exp_acc, rq, $sformatf("accesses page %0d", p), n, exp_acc);
      if (exp_acc == 0) chk(lat == 1, "R3", "hit latency", lat, 1);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin
      logic [23:0] pa;
      logic flt;
      int n;
      int lat;
      for (int i = 0; i < 5; i++) mem_q[int'(ROOT) + i] = VLD | (32'h1000 + i * 128);
      for (int p = 0; p < 33; p++) mem_q[l2a_of(p)] = VLD | 32'(pfn_of(p));
      mem_q[16'h1000 + 127] = 32'h0000_0123;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !rsp_valid && !mem_req, "R11", "reset idle",
          {req_ready, rsp_valid, mem_req}, 3'b100);

      // R1 R6: first touches walk both levels and write back the referenced bit
      for (int p = 0; p < 32; p++) begin
         page_ok(p, (p * 37) % 512, 1'b0, 3, "R6");
         chk(busy_seen, "R11", "busy after accept", busy_seen, 1);
         chk(rd(l2a_of(p)) == (VLD | REF | 32'(pfn_of(p))), "R6",
             "entry after read", rd(l2a_of(p)), VLD | REF | 32'(pfn_of(p)));
      end
      // R3: all 32 translations hit
      for (int p = 0; p < 32; p++) page_ok(p, 511 - p, 1'b0, 0, "R3");

      // R9: flush forces a walk; referenced already set so no write-back (R6)
      do_flush();
      page_ok(0, 5, 1'b0, 2, "R9");
      // R7: write to clean cached page walks and sets modified
      page_ok(0, 6, 1'b1, 3, "R7");
      chk(rd(l2a_of(0)) == (VLD | REF | MOD | 32'(pfn_of(0))), "R7",
          "modified set", rd(l2a_of(0)), VLD | REF | MOD | 32'(pfn_of(0)));
      page_ok(0, 7, 1'b1, 0, "R7");
      page_ok(0, 8, 1'b0, 0, "R3");

      // R8: fill slots 1..31, then a new page evicts slot 0
      for (int p = 1; p < 32; p++) page_ok(p, p, 1'b0, 2, "R8");
      page_ok(32, 100, 1'b0, 3, "R8");
      page_ok(1, 9, 1'b0, 0, "R8");
      page_ok(31, 9, 1'b0, 0, "R8");
      page_ok(0, 9, 1'b0, 2, "R8");
      chk(rd(l2a_of(0)) == (VLD | REF | MOD | 32'(pfn_of(0))), "R6",
          "read keeps modified", rd(l2a_of(0)), VLD | REF | MOD | 32'(pfn_of(0)));

      // R4: invalid first-level word
      xlate({8'd200, 7'd3, 9'd4}, 1'b0, pa, flt, n, lat);
      chk(flt == 1'b1, "R4", "fault", flt, 1);
      chk(n == 1, "R4", "accesses", n, 1);
      chk(pa == 24'h0, "R4", "paddr", pa, 0);
      // R5: invalid page entry, not cached, not written
      for (int k = 0; k < 2; k++) begin
         xlate({8'd0, 7'd127, 9'd17}, 1'b1, pa, flt, n, lat);
         chk(flt == 1'b1, "R5", "fault", flt, 1);
         chk(n == 2, "R5", "accesses", n, 2);
         chk(rd(16'h1000 + 127) == 32'h0000_0123, "R5", "entry unchanged",
             rd(16'h1000 + 127), 32'h123);
      end

      // R7: write upgrade on a clean cached page in another first-level slot
      page_ok(21, 44, 1'b1, 3, "R7");
      page_ok(21, 45, 1'b1, 0, "R7");
      // R1: other first-level slots still translate after flush
      do_flush();
      page_ok(32, 3, 1'b0, 2, "R1");
      page_ok(17, 4, 1'b0, 2, "R1");

      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end
endmodule